// File: doc/BRIEF.md
# Shared-MAC Multichannel FIR Filter Engine

This block applies a 10-tap FIR filter to each of 32 audio channels in a frame, using a single multiply-accumulate datapath that walks through the channels one after another. A one-cycle start strobe hands over a frame of 34 signed 32-bit samples in parallel. The first 32 lanes are filtered. Each of those lanes keeps its own delay-line history in a RAM, and adjacent lane pairs draw their coefficients from one of four coefficient banks. The two highest lanes are returned unchanged. When the whole output frame is ready, a one-cycle done pulse is raised, and the outputs hold that frame until the next done pulse.

The datapath handles two taps per clock. It reads a pair of history words, performs two signed 32x32 multiplies into a 64-bit accumulator, and writes the pair back one position later, so the oldest sample falls off the end. The 64-bit sum is shifted right by 28 bits (coefficients in Q28) and saturated to 32 bits. A symmetric mode mirrors coefficients 0..4 onto taps 9..5, so only half of each bank is looked up. Coefficients are written through a simple register write port while the engine is idle.

Top module: `tdm_fir_engine`

## Requirements
- R1: After synchronous reset, `frame_out` is zero, `frame_done` and `overrun` are low, and `busy` stays high for exactly 160 cycles while the history RAM is zeroed. The first frame therefore filters against an all-zero history.
- R2: Each filtered lane outputs the saturated value of (sum over k=0..9 of c[k]*x[n-k]) arithmetically shifted right by 28. Here x[n] is the sample of the current frame, the products are signed 64-bit, and the sum wraps in 64 bits.
- R3: Each filtered lane keeps an independent 10-sample history that only that lane's own samples update, once per accepted frame.
- R4: Lane c uses the coefficient bank given by the 2-bit field `pair_bank[(c/2)*2 +: 2]`, so lanes 2p and 2p+1 share a bank.
- R5: A shifted result above 2^31-1 yields 0x7FFFFFFF, and one below -2^31 yields 0x80000000.
- R6: Lanes 32 and 33 of `frame_out` equal lanes 32 and 33 of the accepted `frame_in`.
- R7: `frame_done` is high for exactly one cycle, 162 clock cycles after the edge that accepts `frame_start`. `frame_out` changes only in that same cycle, and `busy` is low while `frame_done` is high.
- R8: A `frame_start` while `busy` is high is ignored, so the frame in progress completes with its original data. It also sets `overrun`, which stays high until reset.
- R9: With `sym_mode` high, taps k >= 5 use coefficient 9-k of the bank, and the stored values of taps 5..9 have no effect on the output.
- R10: A clock edge with `coef_we` high stores `coef_data` as tap `coef_tap` (0..9) of bank `coef_bank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Accept `frame_in` as a new frame when not busy |
| frame_in | input | 1088 | 34 signed 32-bit samples, lane i at bits [32i+31:32i] |
| pair_bank | input | 32 | Bank index per lane pair, 2 bits per pair |
| sym_mode | input | 1 | Mirror coefficients 0..4 onto taps 9..5 |
| coef_we | input | 1 | Coefficient write enable |
| coef_bank | input | 2 | Coefficient bank to write |
| coef_tap | input | 4 | Tap index to write |
| coef_data | input | 32 | Signed Q28 coefficient value |
| frame_out | output | 1088 | Output frame, same lane layout as `frame_in` |
| frame_done | output | 1 | One-cycle pulse when `frame_out` is updated |
| busy | output | 1 | High while clearing or processing |
| overrun | output | 1 | Sticky flag for a start strobe while busy |

## Verification
A corrupted history word does not show up once and then vanish. It stays in the delay line for up to ten frames, shifting one tap per frame, so a single bad write reappears as wrong outputs on one lane in several consecutive frames. An impulse frame makes this visible right away because each output is then a scaled coefficient. A wrong bank or mirror index shows up in the very next done cycle as an output built from the wrong coefficients. A sequencing fault moves the done pulse away from cycle 162, or leaves the last lane stale in the captured frame.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/tdm_fir_line_ram.sv
// History store: two word-wide lanes (even and odd tap slot), each a
// simple dual-port RAM with a registered read, so block RAM can be used.
module tdm_fir_line_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 160,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic [AW-1:0]  rd_addr,
  output logic [2*W-1:0] rd_pair,
  input  logic           we,
  input  logic [AW-1:0]  wr_addr,
  input  logic [2*W-1:0] wr_pair
);
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_pair[l*W +: W];
      rd_q <= mem[rd_addr];
    end
    assign rd_pair[l*W +: W] = rd_q;
  end
endmodule

// File: rtl/tdm_fir_coef_rf.sv
// Coefficient register file: BANKS x TAPS words, two combinational reads
// per step, with optional mirroring for symmetric filters.
module tdm_fir_coef_rf #(
  parameter int W     = 32,
  parameter int TAPS  = 10,
  parameter int BANKS = 4,
  parameter int BW    = $clog2(BANKS),
  parameter int TW    = $clog2(TAPS),
  parameter int SW    = $clog2(TAPS/2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [BW-1:0] wbank,
  input  logic [TW-1:0] wtap,
  input  logic [W-1:0]  wdata,
  input  logic [BW-1:0] rbank,
  input  logic [SW-1:0] step,
  input  logic          sym,
  output logic [W-1:0]  c_even,
  output logic [W-1:0]  c_odd
);
  localparam int HALF = TAPS / 2;

  logic [W-1:0] cf_q [BANKS][TAPS];
  logic [TW-1:0] ix_e, ix_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++)
        for (int t = 0; t < TAPS; t++)
          cf_q[b][t] <= '0;
    end else if (we && int'(wtap) < TAPS) begin
      cf_q[wbank][wtap] <= wdata;
    end
  end

  always_comb begin
    ix_e = TW'(2 * int'(step));
    ix_o = TW'(2 * int'(step) + 1);
    if (sym) begin
      if (int'(ix_e) >= HALF) ix_e = TW'(TAPS - 1 - int'(ix_e));
      if (int'(ix_o) >= HALF) ix_o = TW'(TAPS - 1 - int'(ix_o));
    end
  end

  assign c_even = cf_q[rbank][ix_e];
  assign c_odd  = cf_q[rbank][ix_o];
endmodule

// File: rtl/tdm_fir_mac2.sv
// Dual signed multiply-accumulate with scaled, saturated output.
module tdm_fir_mac2 #(
  parameter int W     = 32,
  parameter int ACC_W = 64,
  parameter int FRAC  = 28
) (
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic signed [W-1:0]     c0,
  input  logic signed [W-1:0]     x0,
  input  logic signed [W-1:0]     c1,
  input  logic signed [W-1:0]     x1,
  output logic signed [ACC_W-1:0] acc_out,
  output logic        [W-1:0]     y_sat
);
  logic signed [ACC_W-1:0] p0, p1, scaled;
  logic fits;

  assign p0      = c0 * x0;
  assign p1      = c1 * x1;
  assign acc_out = acc_in + p0 + p1;
  assign scaled  = acc_out >>> FRAC;
  assign fits    = (&scaled[ACC_W-1:W-1]) | ~(|scaled[ACC_W-1:W-1]);

  always_comb begin
    if (fits)                  y_sat = scaled[W-1:0];
    else if (scaled[ACC_W-1])  y_sat = {1'b1, {(W-1){1'b0}}};
    else                       y_sat = {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/tdm_fir_engine.sv
module tdm_fir_engine
  import tdm_fir_pkg::*;
#(
  parameter int SMP_W   = 32,
  parameter int ACC_W   = 64,
  parameter int FILT_CH = 32,
  parameter int PASS_CH = 2,
  parameter int TAPS    = 10,
  parameter int BANKS   = 4,
  parameter int FRAC    = 28
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 frame_start,
  input  logic [(FILT_CH+PASS_CH)*SMP_W-1:0]   frame_in,
  input  logic [(FILT_CH/2)*$clog2(BANKS)-1:0] pair_bank,
  input  logic                                 sym_mode,
  input  logic                                 coef_we,
  input  logic [$clog2(BANKS)-1:0]             coef_bank,
  input  logic [$clog2(TAPS)-1:0]              coef_tap,
  input  logic [SMP_W-1:0]                     coef_data,
  output logic [(FILT_CH+PASS_CH)*SMP_W-1:0]   frame_out,
  output logic                                 frame_done,
  output logic                                 busy,
  output logic                                 overrun
);
  localparam int NCH   = FILT_CH + PASS_CH;
  localparam int STEPS = TAPS / 2;
  localparam int DEPTH = FILT_CH * STEPS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CHW   = $clog2(FILT_CH);
  localparam int SW    = $clog2(STEPS);
  localparam int BW    = $clog2(BANKS);
  localparam int FW    = FILT_CH * SMP_W;

  seq_state_t st_q;
  logic [CHW-1:0]   ch_q, s2_ch;
  logic [SW-1:0]    step_q, s2_step;
  logic [AW-1:0]    clr_addr_q, s2_addr, rd_addr, wr_addr;
  logic             s2_v, fin_q, issue, clearing, ram_we;
  logic [NCH*SMP_W-1:0] in_q;
  logic [FW-1:0]        work_q;
  logic [2*SMP_W-1:0]   rd_pair, wr_pair;
  logic [SMP_W-1:0]     d0, d1, carry_q, x_cur, tap_a, c_e, c_o, y_sat;
  logic [ACC_W-1:0]     acc_q, acc_base, acc_next;
  logic [BW-1:0]        bank_sel;

  assign issue    = (st_q == ST_RUN);
  assign clearing = (st_q == ST_CLEAR);
  assign busy     = (st_q != ST_IDLE);
  assign rd_addr  = AW'(int'(ch_q) * STEPS + int'(step_q));

  // Stage 2 operands
  assign d0       = rd_pair[SMP_W-1:0];
  assign d1       = rd_pair[2*SMP_W-1:SMP_W];
  assign x_cur    = in_q[int'(s2_ch)*SMP_W +: SMP_W];
  assign tap_a    = (s2_step == '0) ? x_cur : carry_q;
  assign acc_base = (s2_step == '0) ? '0 : acc_q;
  assign bank_sel = pair_bank[int'(s2_ch >> 1)*BW +: BW];

  // History write-back: slot 2s takes the older-by-one sample, 2s+1 takes d0
  assign ram_we  = s2_v | clearing;
  assign wr_addr = clearing ? clr_addr_q : s2_addr;
  assign wr_pair = clearing ? '0 : {d0, tap_a};

  tdm_fir_line_ram #(.W(SMP_W), .DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_pair (rd_pair),
    .we      (ram_we),
    .wr_addr (wr_addr),
    .wr_pair (wr_pair)
  );

  tdm_fir_coef_rf #(.W(SMP_W), .TAPS(TAPS), .BANKS(BANKS)) coef_i (
    .clk    (clk),
    .rst    (rst),
    .we     (coef_we),
    .wbank  (coef_bank),
    .wtap   (coef_tap),
    .wdata  (coef_data),
    .rbank  (bank_sel),
    .step   (s2_step),
    .sym    (sym_mode),
    .c_even (c_e),
    .c_odd  (c_o)
  );

  tdm_fir_mac2 #(.W(SMP_W), .ACC_W(ACC_W), .FRAC(FRAC)) mac_i (
    .acc_in  (acc_base),
    .c0      (c_e),
    .x0      (tap_a),
    .c1      (c_o),
    .x1      (d0),
    .acc_out (acc_next),
    .y_sat   (y_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_CLEAR;
      clr_addr_q <= '0;
      ch_q       <= '0;
      step_q     <= '0;
      s2_v       <= 1'b0;
      s2_ch      <= '0;
      s2_step    <= '0;
      s2_addr    <= '0;
      fin_q      <= 1'b0;
      overrun    <= 1'b0;
      frame_done <= 1'b0;
      frame_out  <= '0;
      work_q     <= '0;
      in_q       <= '0;
      carry_q    <= '0;
      acc_q      <= '0;
    end else begin
      frame_done <= 1'b0;
      s2_v       <= issue;
      s2_ch      <= ch_q;
      s2_step    <= step_q;
      s2_addr    <= rd_addr;
      fin_q      <= s2_v && (s2_ch == CHW'(FILT_CH-1)) && (s2_step == SW'(STEPS-1));

      if (frame_start && busy) overrun <= 1'b1;

      unique case (st_q)
        ST_CLEAR: begin
          clr_addr_q <= clr_addr_q + 1'b1;
          if (clr_addr_q == AW'(DEPTH-1)) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (frame_start) begin
            in_q   <= frame_in;
            ch_q   <= '0;
            step_q <= '0;
            st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (step_q == SW'(STEPS-1)) begin
            step_q <= '0;
            if (ch_q == CHW'(FILT_CH-1)) st_q <= ST_DRAIN;
            else                          ch_q <= ch_q + 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (fin_q) begin
            frame_out[FW-1:0]            <= work_q;
            frame_out[NCH*SMP_W-1:FW]    <= in_q[NCH*SMP_W-1:FW];
            frame_done                   <= 1'b1;
            st_q                         <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (s2_v) begin
        carry_q <= d1;
        acc_q   <= acc_next;
        if (s2_step == SW'(STEPS-1))
          work_q[int'(s2_ch)*SMP_W +: SMP_W] <= y_sat;
      end
    end
  end
endmodule

// File: rtl/tdm_fir_engine_chk.sv
module tdm_fir_engine_chk #(
  parameter int SMP_W   = 32,
  parameter int FILT_CH = 32,
  parameter int PASS_CH = 2,
  parameter int TAPS    = 10
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               frame_start,
  input logic                               busy,
  input logic                               frame_done,
  input logic                               overrun,
  input logic [(FILT_CH+PASS_CH)*SMP_W-1:0] frame_out
);
  localparam int LAT = FILT_CH * (TAPS / 2) + 2;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (frame_start && !busy) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (frame_done) begin
      run_q <= 1'b0;
    end else if (run_q && cnt_q <= CW'(LAT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy); // R7
  AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> run_q && cnt_q == CW'(LAT)); // R7
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q <= CW'(LAT)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> $stable(frame_out)); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (frame_start && busy) |=> overrun); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R8
endmodule

bind tdm_fir_engine tdm_fir_engine_chk #(
  .SMP_W(SMP_W), .FILT_CH(FILT_CH), .PASS_CH(PASS_CH), .TAPS(TAPS)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .busy        (busy),
  .frame_done  (frame_done),
  .overrun     (overrun),
  .frame_out   (frame_out)
);

// File: tb/tdm_fir_engine_tb_top.sv
module tdm_fir_engine_tb_top;
  localparam int NF = 32, NP = 2, NCH = 34, TAPS = 10, NB = 4, W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [NCH*W-1:0] frame_in = '0;
  logic [NF-1:0] pair_bank = '0;
  logic sym_mode = 1'b0;
  logic coef_we = 1'b0;
  logic [1:0] coef_bank = '0;
  logic [3:0] coef_tap = '0;
  logic [W-1:0] coef_data = '0;
  logic [NCH*W-1:0] frame_out;
  logic frame_done, busy, overrun;

  int n_chk = 0;
  int n_fail = 0;

  logic signed [31:0] cf   [NB][TAPS];
  logic signed [31:0] hist [NF][TAPS];
  logic signed [31:0] xs   [NCH];

  always #4 clk = ~clk;

  tdm_fir_engine dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_in(frame_in),
    .pair_bank(pair_bank), .sym_mode(sym_mode), .coef_we(coef_we),
    .coef_bank(coef_bank), .coef_tap(coef_tap), .coef_data(coef_data),
    .frame_out(frame_out), .frame_done(frame_done), .busy(busy), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wr_coef(input int b, input int k, input logic [31:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_bank = 2'(b); coef_tap = 4'(k); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    cf[b][k] = v;
  endtask

  function automatic logic signed [31:0] gen(int pat, int f, int ch);
    case (pat)
      0: return (f == 0) ? 32'sd1048576 : 32'sd0;
      1: return 32'((ch + 1) * (f + 1) * 12345 - 400000);
      2: return 32'sh7FFFFFFF;
      3: return 32'sh80000000;
      default: return 32'((ch * 7919) ^ (f * 104729));
    endcase
  endfunction

  function automatic logic signed [31:0] model(int ch);
    longint acc = 0;
    longint sh;
    int b = int'(pair_bank[(ch/2)*2 +: 2]);
    for (int k = 0; k < TAPS; k++) begin
      int ci = (sym_mode && k >= TAPS/2) ? TAPS - 1 - k : k;
      acc += longint'(cf[b][ci]) * longint'(hist[ch][k]);
    end
    sh = acc >>> 28;
    if (sh > 64'sd2147483647) return 32'sh7FFFFFFF;
    if (sh < -64'sd2147483648) return 32'sh80000000;
    return 32'(sh);
  endfunction

  // Run one frame; optionally strike a second start strobe while busy.
  task automatic run_frame(input int pat, input int f, input string tag, input bit intrude);
    int lat;
    logic [NCH*W-1:0] prev_out;
    for (int c = 0; c < NCH; c++) begin
      xs[c] = gen(pat, f, c);
      frame_in[c*W +: W] = xs[c];
    end
    for (int c = 0; c < NF; c++) begin
      for (int k = TAPS - 1; k > 0; k--) hist[c][k] = hist[c][k-1];
      hist[c][0] = xs[c];
    end
    prev_out = frame_out;
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    frame_start = 1'b0;
    while (!frame_done && lat < 1000) begin
      @(posedge clk);
      lat++;
      #1;
      if (intrude && lat == 20) begin
        frame_start = 1'b1;
        frame_in = ~frame_in;
      end else begin
        frame_start = 1'b0;
      end
      if (!frame_done && lat < 162)
        chk(frame_out == prev_out, "R7", "frame_out held before done", 0, 0);
    end
    chk(lat == 162, "R7", "done latency", lat, 162);
    for (int c = 0; c < NF; c++)
      chk($signed(frame_out[c*W +: W]) == model(c), tag, $sformatf("lane %0d", c),
          longint'($signed(frame_out[c*W +: W])), longint'(model(c)));
    for (int c = NF; c < NCH; c++)
      chk(frame_out[c*W +: W] == xs[c], "R6", $sformatf("pass lane %0d", c),
          longint'(frame_out[c*W +: W]), longint'(xs[c]));
    @(posedge clk);
    #1;
    chk(frame_done == 1'b0, "R7", "done width", frame_done, 0);
  endtask

  initial begin
    int n;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < TAPS; k++) cf[b][k] = '0;
    for (int c = 0; c < NF; c++)
      for (int k = 0; k < TAPS; k++) hist[c][k] = '0;
    for (int p = 0; p < NF/2; p++) pair_bank[p*2 +: 2] = 2'((p * 3 + 1) % 4); // R4 pattern
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(frame_out == '0, "R1", "frame_out after reset", 0, 0);
    chk(frame_done == 1'b0, "R1", "done after reset", frame_done, 0);
    chk(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
    n = 0;
    while (busy && n < 1000) begin
      @(posedge clk);
      n++;
      #1;
    end
    chk(n == 160, "R1", "clear cycles", n, 160);

    for (int b = 0; b < NB; b++)                  // R10 coefficient load
      for (int k = 0; k < TAPS; k++)
        wr_coef(b, k, 32'((k + 1 + 3 * b) << 24));

    for (int f = 0; f < 3; f++) run_frame(0, f, "R1 R2 R4 R10", 1'b0);
    for (int f = 0; f < 3; f++) run_frame(1, f, "R2 R3", 1'b0);
    wr_coef(2, 0, 32'sh7FFFFFFF);
    for (int f = 0; f < 2; f++) run_frame(2, f, "R5", 1'b0);
    for (int f = 0; f < 2; f++) run_frame(3, f, "R5", 1'b0);
    run_frame(4, 0, "R3", 1'b0);

    chk(overrun == 1'b0, "R8", "overrun before strike", overrun, 0);
    run_frame(1, 5, "R8", 1'b1);
    chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
    run_frame(4, 1, "R8", 1'b0);
    chk(overrun == 1'b1, "R8", "overrun still set", overrun, 1);

    @(negedge clk);
    sym_mode = 1'b1;
    for (int b = 0; b < NB; b++)                   // R9 junk in mirrored half
      for (int k = TAPS/2; k < TAPS; k++)
        wr_coef(b, k, 32'(32'h5A5A0000 + b * 16 + k));
    for (int f = 0; f < 3; f++) run_frame(1, f + 7, "R9", 1'b0);
    run_frame(4, 3, "R9", 1'b0);

    finish_run();
  end
endmodule